// File: doc/BRIEF.md
# PFC Protection and Fault Supervisor

This block is the digital supervisor of a boost power-factor-correction controller. Analog comparators outside it report threshold crossings as synchronous logic levels. The inputs cover line brownout, a collapsed or open bulk-sense divider, two independent bulk overvoltage levels, the enable pin, the bulk level relative to its good and low thresholds, low line, and light load. Every fault input passes through its own blanking counter, so a glitch shorter than that input's time has no effect.

The filtered faults drive a state machine with these states: off, strap sampling, soft-start, run, auto-restart hold, latched lockout, and standby. Each fault has its own way out. The first overvoltage level only masks the gate while it lasts. Brownout, open loop and an auto-mode second overvoltage all pass through a soft-start. A latched second overvoltage holds until the supply-good input drops. Once after each supply rise, the enable pin is strapped to pick latch or auto-restart handling for the second overvoltage.

The block also qualifies the boost-follower current source. The source is on only while the stage runs and low line and light load have both been seen through their long blanking windows. All times are counts of system-clock ticks set by parameters.

Top module: `pfc_fault_supervisor`

## Requirements
- R1: Each fault input must stay asserted for its full blanking count of consecutive clocks (brownout BROWN_TICKS, open loop OPEN_TICKS, each overvoltage OV1_TICKS/OV2_TICKS, enable-low EN_TICKS) before it acts. Any deassertion restarts the count, so shorter pulses have no effect.
- R2: A qualified brownout (`line_below_off` high) turns `gate_en` off. Restart happens only after `line_above_on` is seen high, and it goes through soft-start.
- R3: A qualified open loop (`vs_open` high) turns `gate_en` off. Once `vs_open` is low, the stage soft-restarts.
- R4: A qualified first overvoltage (`ov1_trip`) forces `gate_en` low without any state change. Gating resumes, with no soft-start, as soon as `ov1_rel` is high.
- R5: In latch mode, a qualified second overvoltage (`ov2_trip`) holds `gate_en` low regardless of later inputs. Only a low level on `vcc_ok` followed by a new power-up clears it.
- R6: In auto mode, a qualified second overvoltage turns the gate off. A soft-start follows once `ov2_rel` is high.
- R7: After each rise of `vcc_ok`, `en_below` is sampled once and must hold its level for STRAP_TICKS clocks. Low (pin high) selects latch mode and high (pin low) selects auto mode. The choice stays fixed until the next power-up.
- R8: If both overvoltage levels are qualified, the gate stays off until both `ov2_rel` and `ov1_rel` have been seen. Running then resumes directly, without soft-start.
- R9: `en_below` qualified for EN_TICKS puts the block in standby with the gate off. Its release starts a soft-start.
- R10: `bulk_ok` rises only while in soft-start with `bulk_at_95` high; that event also ends soft-start. It falls when `bulk_below_low` is high or `vcc_ok` is low, and it does not rise again in run.
- R11: `bofo_src_en` is high only in run, after `low_line` has been stable for LINE_TICKS and `light_load` for LOAD_SET_TICKS. `light_load` deasserting for LOAD_CLR_TICKS turns it off. It is always off during soft-start.
- R12: While the boost follower is on, `vs_bofo_low` held for DROOP_TICKS turns it off. It stays off until the stage leaves run and returns to it.
- R13: A latched fault outranks auto-restart faults, which outrank standby. A latched overvoltage that coincides with a brownout stays locked after both clear.
- R14: After reset or supply rise, `gate_en` and `soft_start` stay low through strap sampling and until `line_above_on` is seen. The block then enters soft-start with `soft_start` and `gate_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Supply above undervoltage lockout |
| line_above_on | input | 1 | Line sense above restart threshold |
| line_below_off | input | 1 | Line sense below brownout threshold |
| vs_open | input | 1 | Bulk sense below open-loop level |
| ov1_trip | input | 1 | Bulk sense above first overvoltage level |
| ov1_rel | input | 1 | Bulk sense below first overvoltage release level |
| ov2_trip | input | 1 | Second overvoltage input above its trip level |
| ov2_rel | input | 1 | Second overvoltage input below its release level |
| en_below | input | 1 | Enable pin below disable threshold |
| bulk_at_95 | input | 1 | Bulk at or above 95 % of rated |
| bulk_below_low | input | 1 | Bulk below externally set low threshold |
| low_line | input | 1 | Line sense below low-line level |
| light_load | input | 1 | Load sense below light-load level |
| vs_bofo_low | input | 1 | Bulk sense below boost-follower floor |
| gate_en | output | 1 | Permission to switch the power stage |
| soft_start | output | 1 | Soft-start in progress |
| bulk_ok | output | 1 | Bulk-voltage-good indication |
| bofo_src_en | output | 1 | Boost-follower current source enable |

## Verification
The bench aims at glitches one blanking window short, and at pulses interrupted and restarted. A filter that does not restart its count on deassertion would trip on those. It recovers from each fault by its own path, with `bulk_at_95` held low so that an unwanted soft-start shows up on `soft_start`. A design that routed every recovery through one common path would show a soft-start after a first-overvoltage event or a dual overvoltage, or no soft-start after a brownout or standby. It strapped both modes and checked that a latched overvoltage, including one that coincides with a brownout, survives its own release and clears only on a supply cycle. The boost-follower checks cover the asymmetric light-load windows, the droop kill that must stay off, and the inhibit during soft-start.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_STRAP,
        ST_SOFT,
        ST_RUN,
        ST_HOLD,
        ST_LOCK,
        ST_IDLE
    } sup_state_e;

    // index of each blanked fault inside the filter bank
    localparam int NFLT     = 5;
    localparam int FI_BROWN = 0;
    localparam int FI_OPEN  = 1;
    localparam int FI_OV1   = 2;
    localparam int FI_OV2   = 3;
    localparam int FI_EN    = 4;

    typedef struct packed {
        logic brown;
        logic open;
        logic ov1;
        logic ov2;
        logic lock;
        logic idle;
    } flag_t;

    function automatic logic auto_pending(flag_t f);
        return f.brown | f.open | f.ov2;
    endfunction

    function automatic logic in_switching(sup_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/pfc_blank_filter.sv
module pfc_blank_filter #(
    parameter int unsigned SET_TICKS = 4,
    parameter int unsigned CLR_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned MAXT = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SET_TICKS - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLR_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim = q ? CLR_LAST : SET_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= 1'b0;
            cnt_q <= '0;
        end else if (d == q) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim) begin
            q     <= d;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // output moves only after the input disagreed with it
    assert_blank_R1: assert property (@(posedge clk) disable iff (rst)
        (q != $past(q)) |-> ($past(d) != $past(q)));

endmodule

// File: rtl/pfc_sup_fsm.sv
module pfc_sup_fsm
    import pfc_sup_pkg::*;
#(
    parameter int unsigned STRAP_TICKS = 4500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vcc_ok,
    input  logic [NFLT-1:0] trip,
    input  logic            line_above_on,
    input  logic            vs_open,
    input  logic            ov1_rel,
    input  logic            ov2_rel,
    input  logic            en_below,
    input  logic            bulk_at_95,
    input  logic            bulk_below_low,
    output logic            gate_en,
    output logic            soft_start,
    output logic            bulk_ok,
    output logic            run
);
    localparam int SW = $clog2(STRAP_TICKS + 1);
    localparam logic [SW-1:0] STRAP_LAST = SW'(STRAP_TICKS - 1);

    sup_state_e    st_q, st_d;
    flag_t         fl_q, fl_d;
    logic          lock_mode_q;
    logic          strap_lvl_q;
    logic [SW-1:0] strap_cnt_q;
    logic          dual_q;
    logic          strap_done;

    assign strap_done = (st_q == ST_STRAP) && (en_below == strap_lvl_q)
                        && (strap_cnt_q == STRAP_LAST);

    // sticky fault flags: set by a qualified trip, cleared by each fault's own release
    always_comb begin
        fl_d = fl_q;
        if (!vcc_ok || st_q == ST_OFF) begin
            fl_d       = '0;
            fl_d.brown = 1'b1;
        end else begin
            if (trip[FI_BROWN])  fl_d.brown = 1'b1;
            else if (line_above_on) fl_d.brown = 1'b0;
            if (trip[FI_OPEN])   fl_d.open = 1'b1;
            else if (!vs_open)   fl_d.open = 1'b0;
            if (trip[FI_OV1])    fl_d.ov1 = 1'b1;
            else if (ov1_rel)    fl_d.ov1 = 1'b0;
            if (trip[FI_OV2] && !lock_mode_q) fl_d.ov2 = 1'b1;
            else if (ov2_rel)    fl_d.ov2 = 1'b0;
            if (trip[FI_OV2] && lock_mode_q && st_q != ST_STRAP) fl_d.lock = 1'b1;
            if (trip[FI_EN])     fl_d.idle = 1'b1;
            else if (!en_below)  fl_d.idle = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!vcc_ok) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF:   st_d = ST_STRAP;
                ST_STRAP: if (strap_done) st_d = ST_HOLD;
                ST_LOCK:  st_d = ST_LOCK;
                default: begin
                    if (fl_q.lock)              st_d = ST_LOCK;
                    else if (auto_pending(fl_q)) st_d = ST_HOLD;
                    else if (fl_q.idle)          st_d = ST_IDLE;
                    else begin
                        case (st_q)
                            ST_HOLD: st_d = dual_q ? ST_RUN : ST_SOFT;
                            ST_IDLE: st_d = ST_SOFT;
                            ST_SOFT: st_d = bulk_at_95 ? ST_RUN : ST_SOFT;
                            default: st_d = st_q;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_OFF;
            fl_q        <= '0;
            lock_mode_q <= 1'b1;
            strap_lvl_q <= 1'b0;
            strap_cnt_q <= '0;
            dual_q      <= 1'b0;
            bulk_ok     <= 1'b0;
        end else begin
            st_q <= st_d;
            fl_q <= fl_d;

            if (st_q != ST_STRAP) begin
                strap_lvl_q <= en_below;
                strap_cnt_q <= '0;
            end else if (en_below != strap_lvl_q) begin
                strap_lvl_q <= en_below;
                strap_cnt_q <= '0;
            end else if (strap_cnt_q != STRAP_LAST) begin
                strap_cnt_q <= strap_cnt_q + 1'b1;
            end
            if (strap_done) lock_mode_q <= ~strap_lvl_q;

            if (st_q != ST_HOLD)              dual_q <= 1'b0;
            else if (fl_q.ov1 && fl_q.ov2)    dual_q <= 1'b1;

            if (!vcc_ok || bulk_below_low)             bulk_ok <= 1'b0;
            else if (st_q == ST_SOFT && bulk_at_95)    bulk_ok <= 1'b1;
        end
    end

    assign gate_en    = in_switching(st_q) && !fl_q.ov1;
    assign soft_start = (st_q == ST_SOFT);
    assign run        = (st_q == ST_RUN);

    assert_brown_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (trip[FI_BROWN] && vcc_ok) |=> ##1 !gate_en);
    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && vcc_ok) |=> (st_q == ST_LOCK));
    assert_hold_soft_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && !dual_q) |=> (st_q != ST_RUN));
    assert_strap_once_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_STRAP) |=> $stable(lock_mode_q));
    assert_idle_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> (st_q != ST_RUN));
    assert_bulk_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bulk_ok) |-> ($past(st_q) == ST_SOFT));

endmodule

// File: rtl/pfc_bofo_qual.sv
module pfc_bofo_qual #(
    parameter int unsigned LINE_TICKS     = 8000000,
    parameter int unsigned LOAD_SET_TICKS = 8000000,
    parameter int unsigned LOAD_CLR_TICKS = 1000000,
    parameter int unsigned DROOP_TICKS    = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic low_line,
    input  logic light_load,
    input  logic vs_bofo_low,
    output logic src_en
);
    logic line_f, load_f, droop_f, kill_q;

    pfc_blank_filter #(.SET_TICKS(LINE_TICKS), .CLR_TICKS(LINE_TICKS)) u_line (
        .clk(clk), .rst(rst), .d(low_line), .q(line_f));
    pfc_blank_filter #(.SET_TICKS(LOAD_SET_TICKS), .CLR_TICKS(LOAD_CLR_TICKS)) u_load (
        .clk(clk), .rst(rst), .d(light_load), .q(load_f));
    pfc_blank_filter #(.SET_TICKS(DROOP_TICKS), .CLR_TICKS(1)) u_droop (
        .clk(clk), .rst(rst), .d(vs_bofo_low), .q(droop_f));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_en <= 1'b0;
            kill_q <= 1'b0;
        end else begin
            if (!run)                  kill_q <= 1'b0;
            else if (droop_f && src_en) kill_q <= 1'b1;
            src_en <= run && line_f && load_f && !kill_q;
        end
    end

    assert_bofo_run_R11: assert property (@(posedge clk) disable iff (rst)
        src_en |-> $past(run));
    assert_bofo_kill_R12: assert property (@(posedge clk) disable iff (rst)
        kill_q |=> !src_en);

endmodule

// File: rtl/pfc_fault_supervisor.sv
module pfc_fault_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int unsigned BROWN_TICKS    = 5000,
    parameter int unsigned OPEN_TICKS     = 250,
    parameter int unsigned OV1_TICKS      = 3000,
    parameter int unsigned OV2_TICKS      = 3000,
    parameter int unsigned EN_TICKS       = 2250,
    parameter int unsigned STRAP_TICKS    = 4500,
    parameter int unsigned LINE_TICKS     = 8000000,
    parameter int unsigned LOAD_SET_TICKS = 8000000,
    parameter int unsigned LOAD_CLR_TICKS = 1000000,
    parameter int unsigned DROOP_TICKS    = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_ok,
    input  logic line_above_on,
    input  logic line_below_off,
    input  logic vs_open,
    input  logic ov1_trip,
    input  logic ov1_rel,
    input  logic ov2_trip,
    input  logic ov2_rel,
    input  logic en_below,
    input  logic bulk_at_95,
    input  logic bulk_below_low,
    input  logic low_line,
    input  logic light_load,
    input  logic vs_bofo_low,
    output logic gate_en,
    output logic soft_start,
    output logic bulk_ok,
    output logic bofo_src_en
);
    localparam int unsigned TRIP_T [NFLT] =
        '{BROWN_TICKS, OPEN_TICKS, OV1_TICKS, OV2_TICKS, EN_TICKS};

    logic [NFLT-1:0] raw, trip;
    logic            run;

    assign raw = {en_below, ov2_trip, ov1_trip, vs_open, line_below_off};

    for (genvar g = 0; g < NFLT; g++) begin : g_blank
        pfc_blank_filter #(.SET_TICKS(TRIP_T[g]), .CLR_TICKS(1)) u_flt (
            .clk(clk), .rst(rst), .d(raw[g]), .q(trip[g]));
    end

    pfc_sup_fsm #(.STRAP_TICKS(STRAP_TICKS)) u_fsm (
        .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .trip(trip),
        .line_above_on(line_above_on), .vs_open(vs_open),
        .ov1_rel(ov1_rel), .ov2_rel(ov2_rel), .en_below(en_below),
        .bulk_at_95(bulk_at_95), .bulk_below_low(bulk_below_low),
        .gate_en(gate_en), .soft_start(soft_start), .bulk_ok(bulk_ok), .run(run));

    pfc_bofo_qual #(
        .LINE_TICKS(LINE_TICKS), .LOAD_SET_TICKS(LOAD_SET_TICKS),
        .LOAD_CLR_TICKS(LOAD_CLR_TICKS), .DROOP_TICKS(DROOP_TICKS)
    ) u_bofo (
        .clk(clk), .rst(rst), .run(run), .low_line(low_line),
        .light_load(light_load), .vs_bofo_low(vs_bofo_low), .src_en(bofo_src_en));

endmodule

// File: tb/pfc_fault_supervisor_test.sv
module pfc_fault_supervisor_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ok = 0, line_above_on = 0, line_below_off = 0, vs_open = 0;
    logic ov1_trip = 0, ov1_rel = 1, ov2_trip = 0, ov2_rel = 1, en_below = 0;
    logic bulk_at_95 = 0, bulk_below_low = 0, low_line = 0, light_load = 0, vs_bofo_low = 0;
    logic gate_en, soft_start, bulk_ok, bofo_src_en;

    int n_run = 0;
    int n_fail = 0;

    localparam int STRAP = 18;

    always #2 clk = ~clk;

    pfc_fault_supervisor #(
        .BROWN_TICKS(20), .OPEN_TICKS(4), .OV1_TICKS(12), .OV2_TICKS(12),
        .EN_TICKS(9), .STRAP_TICKS(STRAP), .LINE_TICKS(64),
        .LOAD_SET_TICKS(64), .LOAD_CLR_TICKS(8), .DROOP_TICKS(4)
    ) uut (.*);

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic power_up(input logic latch_strap);
        vcc_ok = 0; cyc(3);
        en_below = ~latch_strap;
        vcc_ok = 1;
        cyc(STRAP + 8);
        en_below = 0;
        cyc(6);
    endtask

    task automatic t_reset_and_start();
        cyc(3); rst = 0; cyc(2);
        chk("R14", "gate after reset", gate_en, 0);
        chk("R14", "soft after reset", soft_start, 0);
        chk("R10", "bulk_ok after reset", bulk_ok, 0);
        chk("R11", "bofo after reset", bofo_src_en, 0);
        power_up(0);              // auto strap, line not yet above restart level
        chk("R14", "gate waits for line", gate_en, 0);
        line_above_on = 1; cyc(4);
        chk("R14", "soft-start entered", soft_start, 1);
        chk("R14", "gate in soft-start", gate_en, 1);
        bulk_at_95 = 1; cyc(3);
        chk("R10", "bulk_ok at 95%", bulk_ok, 1);
        chk("R10", "soft-start ends", soft_start, 0);
    endtask

    task automatic t_brownout();
        line_above_on = 0;
        line_below_off = 1; cyc(17); line_below_off = 0; cyc(1);
        line_below_off = 1; cyc(17); line_below_off = 0; cyc(3);
        chk("R1", "interrupted brownout ignored", gate_en, 1);
        line_below_off = 1; cyc(28); line_below_off = 0;
        chk("R2", "brownout gate off", gate_en, 0);
        bulk_at_95 = 0; cyc(10);
        chk("R2", "no restart below on level", gate_en, 0);
        line_above_on = 1; cyc(4);
        chk("R2", "restart via soft-start", soft_start, 1);
        bulk_at_95 = 1; cyc(3);
    endtask

    task automatic t_open_loop();
        vs_open = 1; cyc(8);
        chk("R3", "open loop gate off", gate_en, 0);
        bulk_at_95 = 0; vs_open = 0; cyc(4);
        chk("R3", "open loop soft-restart", soft_start, 1);
        bulk_at_95 = 1; cyc(3);
    endtask

    task automatic t_ovp1();
        bulk_at_95 = 0;
        ov1_trip = 1; ov1_rel = 0; cyc(16);
        chk("R4", "ov1 gate off", gate_en, 0);
        ov1_trip = 0; cyc(5);
        chk("R4", "gate off until release", gate_en, 0);
        ov1_rel = 1; cyc(3);
        chk("R4", "gate resumes", gate_en, 1);
        chk("R4", "no soft-start after ov1", soft_start, 0);
        bulk_at_95 = 1;
    endtask

    task automatic t_ovp2_auto();
        ov2_trip = 1; ov2_rel = 0; cyc(16);
        chk("R6", "ov2 auto gate off", gate_en, 0);
        bulk_at_95 = 0; ov2_trip = 0; ov2_rel = 1; cyc(4);
        chk("R6", "ov2 auto soft-restart", soft_start, 1);
        chk("R7", "auto strap recovers", gate_en, 1);
        bulk_at_95 = 1; cyc(3);
    endtask

    task automatic t_dual();
        bulk_at_95 = 0;
        ov1_trip = 1; ov1_rel = 0; ov2_trip = 1; ov2_rel = 0; cyc(16);
        chk("R8", "dual gate off", gate_en, 0);
        ov1_trip = 0; ov2_trip = 0; ov2_rel = 1; cyc(6);
        chk("R8", "off until both released", gate_en, 0);
        ov1_rel = 1; cyc(3);
        chk("R8", "dual resumes", gate_en, 1);
        chk("R8", "dual no soft-start", soft_start, 0);
        bulk_at_95 = 1;
    endtask

    task automatic t_standby();
        en_below = 1; cyc(6); en_below = 0; cyc(3);
        chk("R1", "short enable-low ignored", gate_en, 1);
        en_below = 1; cyc(14);
        chk("R9", "standby gate off", gate_en, 0);
        chk("R9", "standby not soft", soft_start, 0);
        bulk_at_95 = 0; en_below = 0; cyc(4);
        chk("R9", "release soft-starts", soft_start, 1);
        bulk_at_95 = 1; cyc(3);
    endtask

    task automatic t_bulk();
        bulk_below_low = 1; cyc(2);
        chk("R10", "bulk_ok low threshold", bulk_ok, 0);
        bulk_below_low = 0; cyc(4);
        chk("R10", "bulk_ok stays low in run", bulk_ok, 0);
    endtask

    task automatic t_bofo();
        low_line = 1; light_load = 1; cyc(40);
        chk("R11", "bofo blanked", bofo_src_en, 0);
        cyc(40);
        chk("R11", "bofo on", bofo_src_en, 1);
        light_load = 0; cyc(5); light_load = 1; cyc(3);
        chk("R11", "short load release ignored", bofo_src_en, 1);
        light_load = 0; cyc(12);
        chk("R11", "load release turns off", bofo_src_en, 0);
        light_load = 1; cyc(70);
        chk("R11", "bofo back on", bofo_src_en, 1);
        vs_bofo_low = 1; cyc(8);
        chk("R12", "droop kills bofo", bofo_src_en, 0);
        vs_bofo_low = 0; cyc(5);
        chk("R12", "bofo stays killed", bofo_src_en, 0);
        vs_open = 1; cyc(8); vs_open = 0; bulk_at_95 = 0; cyc(5);
        chk("R11", "bofo off in soft-start", bofo_src_en, 0);
        bulk_at_95 = 1; cyc(4);
        chk("R12", "bofo rearmed after run re-entry", bofo_src_en, 1);
        low_line = 0; light_load = 0; cyc(80);
    endtask

    task automatic t_latch();
        bulk_at_95 = 0;
        power_up(1);
        chk("R7", "latch strap starts", soft_start, 1);
        bulk_at_95 = 1; cyc(3);
        ov2_trip = 1; ov2_rel = 0; cyc(16);
        chk("R5", "latch gate off", gate_en, 0);
        ov2_trip = 0; ov2_rel = 1; bulk_at_95 = 0; cyc(20);
        chk("R5", "latch holds after release", gate_en, 0);
        chk("R5", "latch no soft-start", soft_start, 0);
        power_up(1);
        chk("R5", "supply cycle clears latch", gate_en, 1);
        bulk_at_95 = 1; cyc(3);
    endtask

    task automatic t_priority();
        line_above_on = 0; line_below_off = 1; ov2_trip = 1; ov2_rel = 0; cyc(30);
        chk("R13", "combined fault gate off", gate_en, 0);
        line_below_off = 0; line_above_on = 1; ov2_trip = 0; ov2_rel = 1; cyc(20);
        chk("R13", "latch outranks brownout", gate_en, 0);
        chk("R13", "no soft-start from lock", soft_start, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_and_start();
        t_brownout();
        t_open_loop();
        t_ovp1();
        t_ovp2_auto();
        t_dual();
        t_standby();
        t_bulk();
        t_bofo();
        t_latch();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule